// File: doc/BRIEF.md
# Single-precision floating-point multiplier

This block multiplies two 32-bit single-precision operands and returns a packed 32-bit product one clock later. Each operand is split into sign, biased exponent and fraction. The implicit leading one is restored to form two 24-bit significands. Their 48-bit unsigned product is normalised by a two-way select on the product's top bit, and the fraction is truncated. The sign is the XOR of the operand signs. The exponent is the sum of the biased exponents, minus the bias of 127, plus one when the product needed a shift.

It is meant to sit inside a datapath that issues one multiply per cycle under a valid strobe. An operand with a zero exponent field is treated as zero. A final biased exponent outside 1..254 raises a flow flag and saturates the packed result. Rounding, NaN/infinity operands and subnormal arithmetic are not handled.

Top module: `fpmul_sp`

## Requirements
- R1: The result fraction is taken from the unsigned 48-bit product of the two significands (fraction with a leading 1 prepended) by truncation. For example, 0xC1900000 times 0x41180000 gives 0xC32B0000.
- R2: When product bit 47 is 0, the result fraction is product bits 45..23 and the result exponent field is ea+eb-127.
- R3: When product bit 47 is 1, the result fraction is product bits 46..24 and the result exponent field is ea+eb-126. For example, 0x3FC00000 squared gives 0x40100000.
- R4: Result bit 31 is the XOR of operand bits 31, in every case, including zero and saturated results.
- R5: If either operand exponent field (bits 30..23) is zero, result bits 30..0 are zero and flow_o is 0.
- R6: If neither exponent field is zero and the final biased exponent is 255 or more, flow_o is 1 and bits 30..0 are 0x7F800000.
- R7: If neither exponent field is zero and the final biased exponent is 0 or less, flow_o is 1 and bits 30..0 are zero.
- R8: Final biased exponents of exactly 1 and exactly 254 are in range: flow_o is 0 and the exponent field carries that value.
- R9: vld_o equals vld_i delayed by exactly one clock, and each result appears in that same cycle.
- R10: In a cycle with vld_i low, res_o and flow_o keep their previous values whatever the operands are.
- R11: While rst_ni is low, res_o, vld_o and flow_o are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vld_i | input | 1 | Operands valid this cycle |
| a_i | input | 32 | Operand A, packed single precision |
| b_i | input | 32 | Operand B, packed single precision |
| vld_o | output | 1 | Result valid |
| res_o | output | 32 | Packed product |
| flow_o | output | 1 | Exponent overflow or underflow |

## Verification
Fixed operand pairs tell the two normalisation paths apart: a product below 2.0 against one at 2.0 or above, and the worked example that must not shift. Operands with a zero exponent field and nonzero fraction bits show whether stale fraction bits leak into a zero result. Exponent pairs that land exactly on 0, 1, 254 and 255 locate the flow boundaries, including one where only the normalisation increment crosses 254. Several hundred random operand pairs, with idle cycles and changing operands between them, check sign handling, exponent arithmetic and the hold behaviour against an independent model.

// File: rtl/fpmul_pkg.sv
package fpmul_pkg;
  localparam int EXP_W  = 8;
  localparam int MAN_W  = 23;
  localparam int WORD_W = 1 + EXP_W + MAN_W;
  localparam int SIG_W  = MAN_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int BIAS   = (2 ** (EXP_W - 1)) - 1;
  localparam int EXP_MAX = (2 ** EXP_W) - 1;

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] exp;
    logic [MAN_W-1:0] man;
  } fp_word_t;
endpackage

// File: rtl/fpmul_unpack.sv
module fpmul_unpack
  import fpmul_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic              sign_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic [SIG_W-1:0]  sig_o,
  output logic              zero_o
);
  fp_word_t f;
  assign f      = fp_word_t'(word_i);
  assign sign_o = f.sign;
  assign exp_o  = f.exp;
  // hidden one restored; zero-exponent operands are flagged, not decoded
  assign sig_o  = {1'b1, f.man};
  assign zero_o = (f.exp == '0);
endmodule

// File: rtl/fpmul_sigmul.sv
module fpmul_sigmul #(
  parameter int SIG_W  = 24,
  parameter int PROD_W = 2 * SIG_W
) (
  input  logic [SIG_W-1:0]  a_i,
  input  logic [SIG_W-1:0]  b_i,
  output logic [PROD_W-1:0] prod_o
);
  localparam int HALF  = (SIG_W + 1) / 2;
  localparam int PAD_W = 2 * HALF;

  logic [PAD_W-1:0]  a_pad, b_pad;
  logic [PROD_W-1:0] pp [4];

  assign a_pad = PAD_W'(a_i);
  assign b_pad = PAD_W'(b_i);

  // four half-width quadrant products, shifted and summed
  for (genvar q = 0; q < 4; q++) begin : g_quad
    localparam int SA = (q % 2) * HALF;
    localparam int SB = (q / 2) * HALF;
    logic [HALF-1:0] xa, xb;
    assign xa    = a_pad[SA +: HALF];
    assign xb    = b_pad[SB +: HALF];
    assign pp[q] = (PROD_W'(xa) * PROD_W'(xb)) << (SA + SB);
  end

  assign prod_o = pp[0] + pp[1] + pp[2] + pp[3];
endmodule

// File: rtl/fpmul_expunit.sv
module fpmul_expunit
  import fpmul_pkg::*;
(
  input  logic [EXP_W-1:0] ea_i,
  input  logic [EXP_W-1:0] eb_i,
  input  logic             zero_i,
  input  logic             norm_i,
  output logic [EXP_W-1:0] exp_o,
  output logic             ovf_o,
  output logic             unf_o
);
  localparam int W = EXP_W + 2;

  logic [EXP_W:0]  sum_c;   // carry-extended raw sum
  logic signed [W-1:0] biased;

  assign sum_c  = {1'b0, ea_i} + {1'b0, eb_i};
  assign biased = $signed({1'b0, sum_c}) - $signed(W'(BIAS)) + $signed(W'(norm_i));

  assign ovf_o = !zero_i && (biased >= $signed(W'(EXP_MAX)));
  assign unf_o = !zero_i && (biased < $signed(W'(1)));

  always_comb begin
    if (zero_i || unf_o) exp_o = '0;
    else if (ovf_o)      exp_o = '1;
    else                 exp_o = biased[EXP_W-1:0];
  end
endmodule

// File: rtl/fpmul_pack.sv
module fpmul_pack
  import fpmul_pkg::*;
(
  input  logic              sign_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [MAN_W-1:0]  man_i,
  input  logic              clear_i,
  output logic [WORD_W-1:0] word_o
);
  fp_word_t f;
  always_comb begin
    f.sign = sign_i;
    f.exp  = exp_i;
    f.man  = clear_i ? '0 : man_i;
  end
  assign word_o = WORD_W'(f);
endmodule

// File: rtl/fpmul_sp.sv
module fpmul_sp
  import fpmul_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic              vld_o,
  output logic [WORD_W-1:0] res_o,
  output logic              flow_o
);
  logic [WORD_W-1:0] op_w [2];
  logic              op_s [2];
  logic [EXP_W-1:0]  op_e [2];
  logic [SIG_W-1:0]  op_g [2];
  logic              op_z [2];

  assign op_w[0] = a_i;
  assign op_w[1] = b_i;

  for (genvar i = 0; i < 2; i++) begin : g_op
    fpmul_unpack u_unpack (
      .word_i (op_w[i]),
      .sign_o (op_s[i]),
      .exp_o  (op_e[i]),
      .sig_o  (op_g[i]),
      .zero_o (op_z[i])
    );
  end

  logic [PROD_W-1:0] prod;
  fpmul_sigmul #(.SIG_W(SIG_W), .PROD_W(PROD_W)) u_sigmul (
    .a_i    (op_g[0]),
    .b_i    (op_g[1]),
    .prod_o (prod)
  );

  // normalisation select on the product's top bit
  logic             norm;
  logic [MAN_W-1:0] man_sel;
  logic             unused_prod_low;
  assign norm    = prod[PROD_W-1];
  assign man_sel = norm ? prod[PROD_W-2 -: MAN_W] : prod[PROD_W-3 -: MAN_W];
  assign unused_prod_low = ^prod[PROD_W-3-MAN_W:0];

  logic             zero_any, ovf, unf;
  logic [EXP_W-1:0] exp_res;
  assign zero_any = op_z[0] | op_z[1];

  fpmul_expunit u_exp (
    .ea_i   (op_e[0]),
    .eb_i   (op_e[1]),
    .zero_i (zero_any),
    .norm_i (norm),
    .exp_o  (exp_res),
    .ovf_o  (ovf),
    .unf_o  (unf)
  );

  logic [WORD_W-1:0] res_d;
  fpmul_pack u_pack (
    .sign_i  (op_s[0] ^ op_s[1]),
    .exp_i   (exp_res),
    .man_i   (man_sel),
    .clear_i (zero_any | ovf | unf),
    .word_o  (res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      res_o  <= '0;
      flow_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        res_o  <= res_d;
        flow_o <= ovf | unf;
      end
    end
  end
endmodule

// File: rtl/fpmul_sp_chk.sv
module fpmul_sp_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        vld_i,
  input logic [31:0] a_i,
  input logic [31:0] b_i,
  input logic        vld_o,
  input logic [31:0] res_o,
  input logic        flow_o
);
  a_r9_vld_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> vld_o);
  a_r9_idle_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> !vld_o);
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> ($stable(res_o) && $stable(flow_o)));
  a_r4_sign_xor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> (res_o[31] == ($past(a_i[31]) ^ $past(b_i[31]))));
  a_r5_zero_operand: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && ((a_i[30:23] == 8'h00) || (b_i[30:23] == 8'h00)))
      |=> ((res_o[30:0] == 31'h0) && !flow_o));
  a_r6_r7_flow_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && flow_o) |-> ((res_o[30:0] == 31'h0) || (res_o[30:0] == 31'h7F800000)));
  a_r8_no_allones_exp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && !flow_o) |-> (res_o[30:23] != 8'hFF));
endmodule

bind fpmul_sp fpmul_sp_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .vld_i  (vld_i),
  .a_i    (a_i),
  .b_i    (b_i),
  .vld_o  (vld_o),
  .res_o  (res_o),
  .flow_o (flow_o)
);

// File: tb/tb_fpmul_sp.sv
module tb_fpmul_sp;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        vld_i = 1'b0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic        vld_o;
  logic [31:0] res_o;
  logic        flow_o;

  fpmul_sp dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (vld_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .vld_o  (vld_o),
    .res_o  (res_o),
    .flow_o (flow_o)
  );

  always #10 clk_i = ~clk_i;  // 50 MHz

  typedef struct {
    logic [31:0] res;
    logic        flow;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 0;

  task automatic check(input bit ok, input string tag, input logic [32:0] act,
                       input logic [32:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // expected {flow, result} from the requirements
  function automatic logic [32:0] model(input logic [31:0] a, input logic [31:0] b);
    logic        s;
    logic [47:0] p;
    logic [22:0] m;
    int          e;
    s = a[31] ^ b[31];
    if (a[30:23] == 0 || b[30:23] == 0) return {1'b0, s, 31'h0};
    p = 48'({1'b1, a[22:0]}) * 48'({1'b1, b[22:0]});
    if (p[47]) begin
      m = p[46:24];
      e = int'(a[30:23]) + int'(b[30:23]) - 126;
    end else begin
      m = p[45:23];
      e = int'(a[30:23]) + int'(b[30:23]) - 127;
    end
    if (e >= 255) return {1'b1, s, 8'hFF, 23'h0};
    if (e <= 0)   return {1'b1, s, 31'h0};
    return {1'b0, s, e[7:0], m};
  endfunction

  task automatic send(input logic [31:0] a, input logic [31:0] b, input string tag);
    logic [32:0] m;
    exp_t it;
    @(negedge clk_i);
    a_i = a; b_i = b; vld_i = 1'b1;
    m = model(a, b);
    it.res = m[31:0]; it.flow = m[32]; it.tag = tag;
    q.push_back(it);
  endtask

  // explicit check against a hand-computed value, plus the scoreboard
  task automatic send_fixed(input logic [31:0] a, input logic [31:0] b,
                            input logic [31:0] r, input logic f, input string tag);
    logic [32:0] m;
    m = model(a, b);
    check(m == {f, r}, {tag, " model"}, m, {f, r});
    send(a, b, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      vld_i = 1'b0; a_i = $urandom; b_i = $urandom;
    end
  endtask

  // monitor
  logic [31:0] last_res = '0;
  logic        last_flow = 1'b0;
  initial begin
    forever begin
      logic exp_v;
      @(posedge clk_i);
      exp_v = vld_i & rst_ni;
      #2;
      if (rst_ni) begin
        check(vld_o == exp_v, "R9 valid latency", 33'(vld_o), 33'(exp_v));
        if (vld_o) begin
          if (q.size() == 0) begin
            check(1'b0, "R9 unexpected result", {flow_o, res_o}, 33'h0);
          end else begin
            exp_t it;
            it = q.pop_front();
            check({flow_o, res_o} == {it.flow, it.res}, it.tag,
                  {flow_o, res_o}, {it.flow, it.res});
          end
        end else begin
          check({flow_o, res_o} == {last_flow, last_res}, "R10 hold",
                {flow_o, res_o}, {last_flow, last_res});
        end
        last_res = res_o; last_flow = flow_o;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    a_i = 32'hC1900000; b_i = 32'h41180000; vld_i = 1'b1;
    repeat (3) @(posedge clk_i);
    #2;
    check({vld_o, flow_o, res_o} == 34'h0, "R11 reset state",
          {flow_o, res_o}, 33'h0);
    @(negedge clk_i);
    vld_i = 1'b0;
    rst_ni = 1'b1;
    idle(2);

    send_fixed(32'hC1900000, 32'h41180000, 32'hC32B0000, 1'b0, "R1 R2 example");
    send_fixed(32'h3FC00000, 32'h3FC00000, 32'h40100000, 1'b0, "R3 normalise");
    send_fixed(32'h3F800000, 32'h3F800000, 32'h3F800000, 1'b0, "R2 unit");
    send_fixed(32'hC0000000, 32'hC0400000, 32'h40C00000, 1'b0, "R4 neg by neg");
    idle(1);
    send_fixed(32'h00000000, 32'hC0000000, 32'h80000000, 1'b0, "R5 zero sign");
    send_fixed(32'h80000123, 32'h3F800000, 32'h80000000, 1'b0, "R5 stale fraction");
    send_fixed(32'h3FC00000, 32'h007FFFFF, 32'h00000000, 1'b0, "R5 zero b");
    send_fixed(32'h7F000000, 32'h7F000000, 32'h7F800000, 1'b1, "R6 overflow");
    send_fixed(32'hFF400000, 32'h3FC00000, 32'hFF800000, 1'b1, "R6 R3 shift overflow");
    send_fixed(32'h00800000, 32'h00800000, 32'h00000000, 1'b1, "R7 underflow");
    send_fixed(32'h00800000, 32'hBF000000, 32'h80000000, 1'b1, "R7 exp zero");
    idle(3);
    send_fixed(32'h7F000000, 32'h3F800000, 32'h7F000000, 1'b0, "R8 exp 254");
    send_fixed(32'h00800000, 32'h3F800000, 32'h00800000, 1'b0, "R8 exp 1");
    send_fixed(32'h00C00000, 32'h3F400000, 32'h00900000, 1'b0, "R8 R3 shift to 1");
    idle(2);

    for (int i = 0; i < 400; i++) begin
      send($urandom, $urandom, "R1 R2 R3 R4 random");
      if ((i % 7) == 0) idle(1 + (i % 3));
    end
    for (int i = 0; i < 200; i++) begin
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      a[30:23] = 8'(100 + ($urandom % 56));
      b[30:23] = 8'(100 + ($urandom % 56));
      send(a, b, "R2 R3 in-range random");
    end
    idle(4);
    check(q.size() == 0, "R9 drained", 33'(q.size()), 33'h0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule